// File: doc/BRIEF.md
# Transmit Cell/Packet Write-Side FIFO Port

This block is the transmit port through which a link-layer device writes 16-bit words into a PHY's transmit buffer. One configuration bit selects between two ways of framing that traffic.

In cell mode the traffic is fixed-size cells. A cell is 53 bytes, carried as 27 words with one pad byte. A cell becomes visible to the read side only once its last word has arrived. A shared status output reports whether one more whole cell fits. When several PHYs share the bus, that output is released (output enable low) until this PHY's address has been seen on the polling address bus.

In packet mode every accepted word is readable at once. The same status output then means "at least N bytes free", where N is a loadable threshold. A second bit chooses between whole-packet framing and fixed-length chunk framing.

The read side is a plain first-word-fall-through port. The serializer that consumes it sits outside this block, and so does the pad driver that turns the output enable into a three-state pin. Configuration inputs are expected to stay constant between resets.

Top module: `txphy_wr_port`

## Requirements
- R1: After reset the FIFO is empty: `rd_valid`=0, `space_val`=1, `runt_err`=0, `ovf_err`=0, and `space_oe`=1 unless multi-PHY cell mode is selected.
- R2: In cell mode (`cfg_pkt_mode`=0), `space_val` is 1 exactly when the free words (DEPTH minus stored words, including a cell in progress) number at least 27.
- R3: In cell mode, the words of a cell become readable only in the cycle after its 27th word is written. The first word is read with `rd_sop`=1.
- R4: In cell mode, a write with `wr_sop`=1 while a cell is incomplete discards the partial cell, starts a new cell with that word, and sets `runt_err`, which stays 1 until reset.
- R5: A word written with `wr_sop`=0 while no cell or packet unit is open is discarded.
- R6: In multi-PHY cell mode, `space_oe` is 0 until the cycle after `phy_addr_in` equals `cfg_phy_addr`. It returns to 0 the cycle after they differ.
- R7: In multi-PHY cell mode, writes are taken only while `space_oe` is 1. Other writes are ignored.
- R8: A write accepted by the framing logic while the FIFO holds DEPTH words is dropped, and `ovf_err` is set until reset.
- R9: In packet chunk submode (`cfg_chunk`=1) a marker opens a unit of CHUNK_WORDS (default 8) words, and later words are dropped until the next marker. In whole-packet submode a marker opens a unit with no length limit.
- R10: In packet mode, `space_val` is 1 exactly when 2 × free words ≥ the threshold loaded by `thr_load`/`thr_value`.
- R11: The packet threshold resets to 8 bytes.
- R12: In packet mode each accepted word is readable in the cycle after it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pkt_mode | input | 1 | 0 = cell mode, 1 = packet mode |
| cfg_chunk | input | 1 | Packet submode: 1 = chunk framing |
| cfg_multi_phy | input | 1 | Enable address-polled output enable (cell mode) |
| cfg_phy_addr | input | ADDR_W | This PHY's polling address |
| thr_load | input | 1 | Load `thr_value` into the packet threshold |
| thr_value | input | THR_W | Packet threshold in bytes |
| wr_en | input | 1 | Write strobe |
| wr_sop | input | 1 | Start marker on the first word of a cell, packet or chunk |
| wr_data | input | 16 | Write word |
| phy_addr_in | input | ADDR_W | Polling address bus |
| space_val | output | 1 | Shared space flag (cell room or byte threshold) |
| space_oe | output | 1 | Drive enable for the shared flag |
| rd_en | input | 1 | Pop one readable word |
| rd_valid | output | 1 | A readable word is present |
| rd_data | output | 16 | Head word |
| rd_sop | output | 1 | Head word carried a start marker |
| runt_err | output | 1 | Sticky short-cell flag |
| ovf_err | output | 1 | Sticky overflow flag |

## Verification
Each accepted write moves the stored-word count at the clock edge that takes it. `space_val`, `ovf_err` and `runt_err` are therefore checked one nanosecond after that edge. Readability follows the same rule: packet words and the last word of a cell show up on `rd_valid` right after their own edge. The output enable lags the address bus by exactly one edge, so the bench checks it once before and once after that edge. Read-back counts let the bench see words that were dropped or ignored.

// File: rtl/txphy_pkg.sv
package txphy_pkg;

   localparam int WORD_W = 16;

   typedef enum logic [1:0] {
      FR_CELL      = 2'd0,
      FR_PKT_WHOLE = 2'd1,
      FR_PKT_CHUNK = 2'd2
   } frame_mode_e;

   typedef struct packed {
      logic              sop;
      logic [WORD_W-1:0] data;
   } fifo_word_t;

endpackage

// File: rtl/txphy_frame_track.sv
module txphy_frame_track
   import txphy_pkg::*;
#(
   parameter int CELL_WORDS  = 27,
   parameter int CHUNK_WORDS = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  frame_mode_e mode,
   input  logic        wr_ok,
   input  logic        sop,
   input  logic        accepted,
   output logic        push_req,
   output logic        abort,
   output logic        commit,
   output logic        runt_o
);

   localparam int UNIT_MAX = (CELL_WORDS > CHUNK_WORDS) ? CELL_WORDS : CHUNK_WORDS;
   localparam int CW       = $clog2(UNIT_MAX + 1);

   logic          open_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nx;
   logic [CW-1:0] unit_len;
   logic          last;
   logic          runt_q;

   always_comb begin
      unit_len = (mode == FR_CELL) ? CW'(CELL_WORDS) : CW'(CHUNK_WORDS);
      push_req = wr_ok & (sop | open_q);
      abort    = wr_ok & sop & open_q & (mode == FR_CELL);
      if (sop)
         cnt_nx = CW'(1);
      else if (mode == FR_PKT_WHOLE)
         cnt_nx = cnt_q;
      else
         cnt_nx = cnt_q + 1'b1;
      last   = (mode != FR_PKT_WHOLE) && (cnt_nx == unit_len);
      commit = accepted & ((mode != FR_CELL) | last);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
         runt_q <= 1'b0;
      end else begin
         if (accepted) begin
            cnt_q  <= cnt_nx;
            open_q <= !last;
         end else if (abort) begin
            open_q <= 1'b0;
         end
         if (abort)
            runt_q <= 1'b1;
      end
   end

   assign runt_o = runt_q;

   a_r4_runt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      runt_q |=> runt_q);

   a_r5_open_has_count: assert property (@(posedge clk) disable iff (!rst_n)
      open_q |-> (cnt_q != '0 && cnt_q <= CW'(UNIT_MAX)));

endmodule

// File: rtl/txphy_fifo.sv
module txphy_fifo
   import txphy_pkg::*;
#(
   parameter int DEPTH = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push_req,
   input  logic                     abort,
   input  logic                     commit,
   input  fifo_word_t               wr_word,
   input  logic                     rd_en,
   output logic                     accepted,
   output logic                     ovf_o,
   output logic                     rd_valid,
   output fifo_word_t               rd_word,
   output logic [$clog2(DEPTH):0]   used_o
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
         $error("txphy_fifo: DEPTH must be a power of two >= 2");
      end
   endgenerate

   fifo_word_t    mem [DEPTH];
   logic [PW-1:0] wspec_q, wcom_q, rd_q;
   logic [PW-1:0] base, wspec_nx;
   logic          full;
   logic          ovf_q;

   always_comb begin
      base     = abort ? wcom_q : wspec_q;
      full     = PW'(base - rd_q) == PW'(DEPTH);
      accepted = push_req & !full;
      wspec_nx = accepted ? base + 1'b1 : base;
      rd_valid = wcom_q != rd_q;
      rd_word  = mem[rd_q[AW-1:0]];
      used_o   = wspec_q - rd_q;
   end

   always_ff @(posedge clk) begin
      if (accepted)
         mem[base[AW-1:0]] <= wr_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wspec_q <= '0;
         wcom_q  <= '0;
         rd_q    <= '0;
         ovf_q   <= 1'b0;
      end else begin
         wspec_q <= wspec_nx;
         if (commit)
            wcom_q <= wspec_nx;
         if (rd_en && rd_valid)
            rd_q <= rd_q + 1'b1;
         if (push_req && full)
            ovf_q <= 1'b1;
      end
   end

   assign ovf_o = ovf_q;

   a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && full && !abort) |=> $stable(wspec_q));

   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);

   a_r3_commit_behind_spec: assert property (@(posedge clk) disable iff (!rst_n)
      PW'(wcom_q - rd_q) <= PW'(wspec_q - rd_q));

endmodule

// File: rtl/txphy_space_flag.sv
module txphy_space_flag #(
   parameter int DEPTH      = 64,
   parameter int CELL_WORDS = 27,
   parameter int THR_W      = 8,
   parameter int THR_RST    = 8,
   parameter int ADDR_W     = 5,
   parameter bit MPHY_EN    = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   pkt_mode,
   input  logic                   multi_phy,
   input  logic [ADDR_W-1:0]      phy_addr_in,
   input  logic [ADDR_W-1:0]      cfg_phy_addr,
   input  logic                   thr_load,
   input  logic [THR_W-1:0]       thr_value,
   input  logic [$clog2(DEPTH):0] used,
   output logic                   space_val,
   output logic                   space_oe,
   output logic                   wr_sel
);

   localparam int PW = $clog2(DEPTH) + 1;

   generate
      if (THR_W < PW + 1) begin : g_bad_thr
         $error("txphy_space_flag: THR_W too narrow for 2*DEPTH bytes");
      end
   endgenerate

   logic [THR_W-1:0] thr_q;
   logic [PW-1:0]    free_words;
   logic [THR_W-1:0] free_bytes;

   always_ff @(posedge clk) begin
      if (!rst_n)
         thr_q <= THR_W'(THR_RST);
      else if (thr_load)
         thr_q <= thr_value;
   end

   always_comb begin
      free_words = PW'(DEPTH) - used;
      free_bytes = THR_W'({free_words, 1'b0});
      space_val  = pkt_mode ? (free_bytes >= thr_q)
                            : (free_words >= PW'(CELL_WORDS));
   end

   generate
      if (MPHY_EN) begin : g_mphy
         logic sel_q;
         logic polled;
         assign polled = multi_phy & !pkt_mode;
         always_ff @(posedge clk) begin
            if (!rst_n)
               sel_q <= 1'b0;
            else
               sel_q <= (phy_addr_in == cfg_phy_addr);
         end
         assign space_oe = !polled | sel_q;
         assign wr_sel   = !polled | sel_q;

         a_r6_release_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
            (polled && phy_addr_in != cfg_phy_addr) |=> (!space_oe || !polled));
         a_r6_drive_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
            (polled && phy_addr_in == cfg_phy_addr) |=> (space_oe || !polled));
      end else begin : g_single
         logic unused_mphy;
         assign unused_mphy = ^{multi_phy, phy_addr_in, cfg_phy_addr};
         assign space_oe = 1'b1;
         assign wr_sel   = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/txphy_wr_port.sv
module txphy_wr_port
   import txphy_pkg::*;
#(
   parameter int DEPTH       = 64,
   parameter int CELL_BYTES  = 53,
   parameter int CHUNK_WORDS = 8,
   parameter int ADDR_W      = 5,
   parameter int THR_RST     = 8,
   parameter bit MPHY_EN     = 1'b1,
   parameter int THR_W       = $clog2(DEPTH) + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_pkt_mode,
   input  logic              cfg_chunk,
   input  logic              cfg_multi_phy,
   input  logic [ADDR_W-1:0] cfg_phy_addr,
   input  logic              thr_load,
   input  logic [THR_W-1:0]  thr_value,
   input  logic              wr_en,
   input  logic              wr_sop,
   input  logic [15:0]       wr_data,
   input  logic [ADDR_W-1:0] phy_addr_in,
   output logic              space_val,
   output logic              space_oe,
   input  logic              rd_en,
   output logic              rd_valid,
   output logic [15:0]       rd_data,
   output logic              rd_sop,
   output logic              runt_err,
   output logic              ovf_err
);

   localparam int CELL_WORDS = (CELL_BYTES + 1) / 2;
   localparam int AW         = $clog2(DEPTH);

   generate
      if (DEPTH < CELL_WORDS) begin : g_bad_cell
         $error("txphy_wr_port: DEPTH must hold a whole cell");
      end
      if (CHUNK_WORDS < 1 || CHUNK_WORDS > DEPTH) begin : g_bad_chunk
         $error("txphy_wr_port: CHUNK_WORDS out of range");
      end
   endgenerate

   frame_mode_e   mode;
   logic          wr_sel, wr_ok;
   logic          push_req, abort, commit, accepted;
   fifo_word_t    in_word, head;
   logic [AW:0]   used;

   assign mode    = !cfg_pkt_mode ? FR_CELL : (cfg_chunk ? FR_PKT_CHUNK : FR_PKT_WHOLE);
   assign wr_ok   = wr_en & wr_sel;
   assign in_word = '{sop: wr_sop, data: wr_data};

   txphy_frame_track #(.CELL_WORDS(CELL_WORDS), .CHUNK_WORDS(CHUNK_WORDS)) u_track (
      .clk(clk), .rst_n(rst_n), .mode(mode), .wr_ok(wr_ok), .sop(wr_sop),
      .accepted(accepted), .push_req(push_req), .abort(abort), .commit(commit),
      .runt_o(runt_err));

   txphy_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push_req(push_req), .abort(abort), .commit(commit),
      .wr_word(in_word), .rd_en(rd_en), .accepted(accepted), .ovf_o(ovf_err),
      .rd_valid(rd_valid), .rd_word(head), .used_o(used));

   txphy_space_flag #(.DEPTH(DEPTH), .CELL_WORDS(CELL_WORDS), .THR_W(THR_W),
                      .THR_RST(THR_RST), .ADDR_W(ADDR_W), .MPHY_EN(MPHY_EN)) u_space (
      .clk(clk), .rst_n(rst_n), .pkt_mode(cfg_pkt_mode), .multi_phy(cfg_multi_phy),
      .phy_addr_in(phy_addr_in), .cfg_phy_addr(cfg_phy_addr), .thr_load(thr_load),
      .thr_value(thr_value), .used(used), .space_val(space_val), .space_oe(space_oe),
      .wr_sel(wr_sel));

   assign rd_data = head.data;
   assign rd_sop  = head.sop;

endmodule

// File: tb/txphy_wr_port_tb.sv
`timescale 1ns/1ps
module txphy_wr_port_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_pkt_mode = 1'b0, cfg_chunk = 1'b0, cfg_multi_phy = 1'b0;
   logic [4:0] cfg_phy_addr = 5'd5, phy_addr_in = 5'd0;
   logic       thr_load = 1'b0;
   logic [7:0] thr_value = 8'd0;
   logic       wr_en = 1'b0, wr_sop = 1'b0;
   logic [15:0] wr_data = 16'd0;
   logic       space_val, space_oe, rd_en = 1'b0, rd_valid, rd_sop, runt_err, ovf_err;
   logic [15:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   txphy_wr_port dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_pkt_mode(cfg_pkt_mode), .cfg_chunk(cfg_chunk),
      .cfg_multi_phy(cfg_multi_phy), .cfg_phy_addr(cfg_phy_addr), .thr_load(thr_load),
      .thr_value(thr_value), .wr_en(wr_en), .wr_sop(wr_sop), .wr_data(wr_data),
      .phy_addr_in(phy_addr_in), .space_val(space_val), .space_oe(space_oe),
      .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_sop(rd_sop),
      .runt_err(runt_err), .ovf_err(ovf_err));

   // packet threshold table: fill words, load flag, threshold, expected flag
   localparam int NV = 8;
   localparam int TV_FILL [NV] = '{0, 60, 61, 10, 11, 64, 32, 33};
   localparam int TV_LOAD [NV] = '{0, 0, 0, 1, 1, 1, 1, 1};
   localparam int TV_THR  [NV] = '{0, 0, 0, 108, 108, 0, 64, 64};
   localparam int TV_EXP  [NV] = '{1, 1, 0, 1, 0, 1, 1, 0};

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick();
      tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic wr_word(int data, bit sop);
      wr_en   = 1'b1;
      wr_sop  = sop;
      wr_data = 16'(data);
      tick();
      wr_en  = 1'b0;
      wr_sop = 1'b0;
   endtask

   task automatic wr_unit(int base, int n);
      for (int i = 0; i < n; i++) wr_word(base + i, i == 0);
   endtask

   task automatic drain(output int n, output int first);
      n = 0;
      first = -1;
      while (rd_valid && n < 200) begin
         if (n == 0) first = int'(rd_data);
         rd_en = 1'b1;
         tick();
         rd_en = 1'b0;
         n++;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int n, first;

      // threshold table walk, R10 and R11
      cfg_pkt_mode = 1'b1;
      for (int v = 0; v < NV; v++) begin
         do_reset();
         if (TV_LOAD[v] != 0) begin
            thr_value = 8'(TV_THR[v]);
            thr_load  = 1'b1;
            tick();
            thr_load  = 1'b0;
         end
         if (TV_FILL[v] > 0) wr_unit(16'h0100, TV_FILL[v]);
         chk(TV_LOAD[v] != 0 ? "R10 threshold" : "R11 default threshold",
             int'(space_val), TV_EXP[v]);
      end

      // R1 reset state in cell mode
      cfg_pkt_mode = 1'b0;
      do_reset();
      chk("R1 space_val", int'(space_val), 1);
      chk("R1 space_oe", int'(space_oe), 1);
      chk("R1 rd_valid", int'(rd_valid), 0);
      chk("R1 runt_err", int'(runt_err), 0);
      chk("R1 ovf_err", int'(ovf_err), 0);

      // R3 / R2 cell commit and room
      for (int i = 0; i < 26; i++) wr_word(16'h1000 + i, i == 0);
      chk("R3 hidden before last word", int'(rd_valid), 0);
      wr_word(16'h1000 + 26, 1'b0);
      chk("R3 visible after last word", int'(rd_valid), 1);
      chk("R3 rd_sop on head", int'(rd_sop), 1);
      chk("R3 head data", int'(rd_data), 16'h1000);
      chk("R2 room for one more cell", int'(space_val), 1);
      for (int i = 0; i < 17; i++) wr_word(16'h1100 + i, i == 0);
      chk("R2 no room with 44 stored", int'(space_val), 0);
      for (int i = 17; i < 27; i++) wr_word(16'h1100 + i, 1'b0);
      drain(n, first);
      chk("R3 two cells read back", n, 54);
      chk("R2 room after drain", int'(space_val), 1);

      // R4 runt cell
      do_reset();
      wr_unit(16'h2000, 5);
      wr_word(16'h3000, 1'b1);
      chk("R4 runt flag", int'(runt_err), 1);
      for (int i = 1; i < 27; i++) wr_word(16'h3000 + i, 1'b0);
      drain(n, first);
      chk("R4 only new cell kept", n, 27);
      chk("R4 new cell first word", first, 16'h3000);
      chk("R4 runt stays set", int'(runt_err), 1);

      // R5 stray words
      do_reset();
      for (int i = 0; i < 3; i++) wr_word(16'h0AA0 + i, 1'b0);
      chk("R5 stray not readable", int'(rd_valid), 0);
      wr_unit(16'h4000, 27);
      for (int i = 0; i < 3; i++) wr_word(16'h0BB0 + i, 1'b0);
      drain(n, first);
      chk("R5 only the cell stored", n, 27);
      chk("R5 cell first word", first, 16'h4000);

      // R6 / R7 multi-PHY polling
      cfg_multi_phy = 1'b1;
      phy_addr_in   = 5'd3;
      do_reset();
      chk("R6 released before match", int'(space_oe), 0);
      wr_unit(16'h5000, 27);
      drain(n, first);
      chk("R7 unselected writes ignored", n, 0);
      phy_addr_in = 5'd5;
      #0;
      chk("R6 no drive before edge", int'(space_oe), 0);
      tick();
      chk("R6 drive after match", int'(space_oe), 1);
      wr_unit(16'h5100, 27);
      drain(n, first);
      chk("R7 selected writes taken", n, 27);
      phy_addr_in = 5'd3;
      tick();
      chk("R6 released after miss", int'(space_oe), 0);
      cfg_multi_phy = 1'b0;

      // R8 overflow in packet mode
      cfg_pkt_mode = 1'b1;
      do_reset();
      wr_unit(16'h6000, 65);
      chk("R8 overflow flag", int'(ovf_err), 1);
      drain(n, first);
      chk("R8 extra word dropped", n, 64);
      chk("R8 overflow stays set", int'(ovf_err), 1);

      // R9 chunk vs whole packet
      cfg_chunk = 1'b1;
      do_reset();
      wr_unit(16'h7000, 10);
      drain(n, first);
      chk("R9 chunk length limit", n, 8);
      wr_unit(16'h7100, 4);
      drain(n, first);
      chk("R9 next marker reopens", n, 4);
      cfg_chunk = 1'b0;
      do_reset();
      wr_unit(16'h7200, 10);
      drain(n, first);
      chk("R9 whole packet unlimited", n, 10);

      // R12 immediate visibility in packet mode
      do_reset();
      wr_word(16'h5555, 1'b1);
      chk("R12 readable next cycle", int'(rd_valid), 1);
      chk("R12 head data", int'(rd_data), 16'h5555);
      chk("R12 head marker", int'(rd_sop), 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule